// File: doc/BRIEF.md
# Hot-Swap Inrush and Power-Good Sequencer

This block is the digital controller behind the pass switch of a powered-device port interface. Analog comparators report where the port voltage, the switch drain-source and gate-source voltages and the die temperature stand. From those flags the block decides three things: whether the pass switch conducts, whether the analog limiter runs at the low charging current or the higher running current, and whether the open-drain power-good pin is released. A second output gates the classification current source.

All timing comes from a tick input that pulses once per microsecond. Each debounce window counts ticks and starts again from zero whenever its qualifying condition lapses. Port undervoltage is filtered in both directions with hysteresis between two comparator levels. Charging ends only when the drain-source and gate-source flags agree for a full window. A drain over-voltage must last for a full window before the block falls back to the charging limit. Thermal shutdown and an asynchronous auxiliary-supply override take the switch away in different ways.

Top module: `pd_hotswap_seq`

## Requirements
- R1: Lockout releases only after portAboveOn has been high for FILT_US (default 100) consecutive ticks. Once released, it engages only after portAboveOff has been low for FILT_US consecutive ticks. The state machine acts one clock after the filtered flag changes.
- R2: When lockout releases, the switch turns on (switchEn=1) with limitOper=0 (charging limit) and pgoodRelease=0 (pin pulled low).
- R3: From charging, vdsLow and vgsHigh must both be high for FILT_US consecutive ticks. Then limitOper and pgoodRelease go to 1 on the clock of the last tick. Either flag alone never ends charging.
- R4: While powered, the port falling below the turn-on level but staying above the turn-off level keeps all outputs unchanged.
- R5: While powered, vdsHigh held for FILT_US consecutive ticks returns the block to charging (limitOper=0, pgoodRelease=0, switchEn=1). A shorter excursion changes nothing, and its count restarts from zero.
- R6: tempHot forces switchEn, limitOper, pgoodRelease and classEn to 0 on the next clock. Operation resumes in charging only when tempHot is low and tempCool is high.
- R7: auxReq passes through a two-flop synchroniser. Three clocks after it rises while powered, switchEn goes to 0 while pgoodRelease stays 1.
- R8: Three clocks after auxReq falls, the block leaves the override state for charging (switchEn=1, limitOper=0, pgoodRelease=0).
- R9: An engaged lockout forces the idle state (switchEn=0, limitOper=0, pgoodRelease=0, classEn=1) from any state, including thermal shutdown.
- R10: Filter counters advance only on clocks where usTick is high. With usTick held low, no filter ever completes.
- R11: auxReq held high while idle or charging keeps the switch off and power-good low. Its release lets charging start three clocks later.
- R12: After reset the outputs are switchEn=0, limitOper=0, pgoodRelease=0, classEn=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| usTick | input | 1 | One-cycle pulse per microsecond |
| portAboveOn | input | 1 | Port voltage above turn-on level |
| portAboveOff | input | 1 | Port voltage above turn-off level |
| vdsLow | input | 1 | Switch drain-source below about 1 V |
| vdsHigh | input | 1 | Switch drain-source above about 10 V |
| vgsHigh | input | 1 | Switch gate-source above about 2 V |
| tempHot | input | 1 | Die above shutdown temperature |
| tempCool | input | 1 | Die below the hysteresis release temperature |
| auxReq | input | 1 | Asynchronous auxiliary-supply override |
| switchEn | output | 1 | Pass switch enable |
| limitOper | output | 1 | 1 = running current limit, 0 = charging limit |
| pgoodRelease | output | 1 | 1 = power-good pin released (high-Z), 0 = pulled low |
| classEn | output | 1 | Classification current source enable |

## Verification
A state machine stuck in the wrong state shows at the four outputs on the very next clock, because every output is decoded straight from the state register. A debounce counter that fails to restart or to count only ticks shows as a transition one or more windows early or late, so the vectors sample one clock before and one clock after each expected filter expiry. A synchroniser of the wrong depth moves the override response off its three-clock mark, and the bench checks both the second and the third clock.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_INRUSH  = 3'd1,
    ST_POWERED = 3'd2,
    ST_TSD     = 3'd3,
    ST_AUX     = 3'd4
  } seq_state_e;

  // control -> datapath: which window filters are armed
  typedef struct packed {
    logic armCharge;
    logic armOver;
  } seq_arm_t;

  // datapath -> control: filtered levels and expiry strobes
  typedef struct packed {
    logic uvloOk;
    logic chargedStb;
    logic overStb;
    logic auxSync;
  } seq_stat_t;

endpackage

// File: rtl/pd_seq_filter.sv
module pd_seq_filter #(
  parameter int FILT_US = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic usTick,
  input  logic qual,
  output logic fire
);
  localparam int CNT_W = (FILT_US > 1) ? $clog2(FILT_US) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_US - 1);

  logic [CNT_W-1:0] cnt;

  assign fire = qual && usTick && (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (!qual || fire) cnt <= '0;
    else if (usTick)        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pd_seq_datapath.sv
module pd_seq_datapath
  import pd_seq_pkg::*;
#(
  parameter int FILT_US = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      usTick,
  input  logic      portAboveOn,
  input  logic      portAboveOff,
  input  logic      vdsLow,
  input  logic      vdsHigh,
  input  logic      vgsHigh,
  input  logic      auxReq,
  input  seq_arm_t  arm,
  output seq_stat_t stat
);
  logic [SYNC_STAGES-1:0] auxPipe;
  logic uvloOk, uvFire, chgFire, ovFire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) auxPipe <= '0;
    else       auxPipe <= {auxPipe[SYNC_STAGES-2:0], auxReq};
  end

  // hysteretic lockout: the qualifying comparator depends on current level
  pd_seq_filter #(.FILT_US(FILT_US)) uvFilt (
    .clk(clk), .rstN(rstN), .usTick(usTick),
    .qual(uvloOk ? !portAboveOff : portAboveOn),
    .fire(uvFire)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       uvloOk <= 1'b0;
    else if (uvFire) uvloOk <= !uvloOk;
  end

  pd_seq_filter #(.FILT_US(FILT_US)) chgFilt (
    .clk(clk), .rstN(rstN), .usTick(usTick),
    .qual(arm.armCharge && vdsLow && vgsHigh),
    .fire(chgFire)
  );

  pd_seq_filter #(.FILT_US(FILT_US)) ovFilt (
    .clk(clk), .rstN(rstN), .usTick(usTick),
    .qual(arm.armOver && vdsHigh),
    .fire(ovFire)
  );

  assign stat.uvloOk     = uvloOk;
  assign stat.chargedStb = chgFire;
  assign stat.overStb    = ovFire;
  assign stat.auxSync    = auxPipe[SYNC_STAGES-1];
endmodule

// File: rtl/pd_seq_ctrl.sv
module pd_seq_ctrl
  import pd_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tempHot,
  input  logic      tempCool,
  input  seq_stat_t stat,
  output seq_arm_t  arm,
  output logic      switchEn,
  output logic      limitOper,
  output logic      pgoodRelease,
  output logic      classEn
);
  seq_state_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state;
    if (!stat.uvloOk)  nxt = ST_OFF;
    else if (tempHot)  nxt = ST_TSD;
    else begin
      case (state)
        ST_OFF:     if (!stat.auxSync) nxt = ST_INRUSH;
        ST_INRUSH:  if (stat.auxSync) nxt = ST_OFF;
                    else if (stat.chargedStb) nxt = ST_POWERED;
        ST_POWERED: if (stat.auxSync) nxt = ST_AUX;
                    else if (stat.overStb) nxt = ST_INRUSH;
        ST_TSD:     if (tempCool) nxt = ST_INRUSH;
        ST_AUX:     if (!stat.auxSync) nxt = ST_INRUSH;
        default:    nxt = ST_OFF;
      endcase
    end
  end

  assign arm.armCharge = (state == ST_INRUSH);
  assign arm.armOver   = (state == ST_POWERED);

  assign switchEn     = (state == ST_INRUSH) || (state == ST_POWERED);
  assign limitOper    = (state == ST_POWERED);
  assign pgoodRelease = (state == ST_POWERED) || (state == ST_AUX);
  assign classEn      = (state != ST_TSD);
endmodule

// File: rtl/pd_hotswap_seq.sv
module pd_hotswap_seq
  import pd_seq_pkg::*;
#(
  parameter int FILT_US = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic usTick,
  input  logic portAboveOn,
  input  logic portAboveOff,
  input  logic vdsLow,
  input  logic vdsHigh,
  input  logic vgsHigh,
  input  logic tempHot,
  input  logic tempCool,
  input  logic auxReq,
  output logic switchEn,
  output logic limitOper,
  output logic pgoodRelease,
  output logic classEn
);
  seq_arm_t  arm;
  seq_stat_t stat;

  pd_seq_datapath #(.FILT_US(FILT_US), .SYNC_STAGES(2)) dp (
    .clk(clk), .rstN(rstN), .usTick(usTick),
    .portAboveOn(portAboveOn), .portAboveOff(portAboveOff),
    .vdsLow(vdsLow), .vdsHigh(vdsHigh), .vgsHigh(vgsHigh),
    .auxReq(auxReq), .arm(arm), .stat(stat)
  );

  pd_seq_ctrl ctrl (
    .clk(clk), .rstN(rstN), .tempHot(tempHot), .tempCool(tempCool),
    .stat(stat), .arm(arm),
    .switchEn(switchEn), .limitOper(limitOper),
    .pgoodRelease(pgoodRelease), .classEn(classEn)
  );
endmodule

// File: rtl/pd_hotswap_seq_chk.sv
module pd_hotswap_seq_chk #(
  parameter int FILT_US = 100
) (
  input logic clk,
  input logic rstN,
  input logic usTick,
  input logic portAboveOff,
  input logic tempHot,
  input logic auxReq,
  input logic switchEn,
  input logic limitOper,
  input logic pgoodRelease
);
  localparam int LW = $clog2(FILT_US + 1);
  localparam logic [LW-1:0] LIM = LW'(FILT_US);

  logic [LW-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      lowCnt <= '0;
    else if (portAboveOff)          lowCnt <= '0;
    else if (usTick && lowCnt != LIM) lowCnt <= lowCnt + 1'b1;
  end

  // R2: while charging the power-good pin is held low
  assert_pg_low_charging_R2: assert property (@(posedge clk) disable iff (!rstN)
    (switchEn && !limitOper) |-> !pgoodRelease);

  // R3: running limit only with switch on and power-good released
  assert_oper_consistent_R3: assert property (@(posedge clk) disable iff (!rstN)
    limitOper |-> (switchEn && pgoodRelease));

  // R6: over-temperature removes switch and power-good next clock
  assert_tsd_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    tempHot |=> (!switchEn && !pgoodRelease));

  // R7: switch dropping with power-good kept released needs the override
  assert_aux_origin_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(switchEn) && pgoodRelease) |-> $past(auxReq, 3));

  // R9: a full low window at the turn-off comparator removes the switch
  assert_uvlo_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    (lowCnt == LIM) |=> !switchEn);
endmodule

bind pd_hotswap_seq pd_hotswap_seq_chk #(.FILT_US(FILT_US)) chk (.*);

// File: tb/pd_hotswap_seq_test.sv
module pd_hotswap_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usTick = 1'b1;
  logic portAboveOn, portAboveOff, vdsLow, vdsHigh, vgsHigh;
  logic tempHot, tempCool, auxReq;
  logic switchEn, limitOper, pgoodRelease, classEn;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pd_hotswap_seq #(.FILT_US(100)) uut (
    .clk(clk), .rstN(rstN), .usTick(usTick),
    .portAboveOn(portAboveOn), .portAboveOff(portAboveOff),
    .vdsLow(vdsLow), .vdsHigh(vdsHigh), .vgsHigh(vgsHigh),
    .tempHot(tempHot), .tempCool(tempCool), .auxReq(auxReq),
    .switchEn(switchEn), .limitOper(limitOper),
    .pgoodRelease(pgoodRelease), .classEn(classEn)
  );

  // ins = {portAboveOn, portAboveOff, vdsLow, vdsHigh, vgsHigh, tempHot, tempCool, auxReq}
  // exp = {switchEn, limitOper, pgoodRelease, classEn}
  typedef struct packed {
    logic [7:0] ins;
    logic [8:0] cyc;
    logic [3:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{8'b01000010, 9'd20,  4'b0001, 4'd1},  // R1 only above turn-off: no start
    '{8'b11000010, 9'd100, 4'b0001, 4'd1},  // R1 filter expired, machine lags one clock
    '{8'b11000010, 9'd1,   4'b1001, 4'd2},  // R2 charging, pin low
    '{8'b11100010, 9'd150, 4'b1001, 4'd3},  // R3 vdsLow alone is not enough
    '{8'b11101010, 9'd99,  4'b1001, 4'd3},  // R3 one tick short
    '{8'b11101010, 9'd1,   4'b1111, 4'd3},  // R3 powered
    '{8'b01101010, 9'd50,  4'b1111, 4'd4},  // R4 between thresholds
    '{8'b01010010, 9'd99,  4'b1111, 4'd5},  // R5 short excursion
    '{8'b01101010, 9'd1,   4'b1111, 4'd5},  // R5 excursion ends
    '{8'b01010010, 9'd99,  4'b1111, 4'd5},  // R5 count restarted
    '{8'b01010010, 9'd1,   4'b1001, 4'd5},  // R5 fall back to charging
    '{8'b01101010, 9'd100, 4'b1111, 4'd3},  // R3 recharged
    '{8'b01101100, 9'd1,   4'b0000, 4'd6},  // R6 thermal trip
    '{8'b01101000, 9'd20,  4'b0000, 4'd6},  // R6 inside hysteresis band
    '{8'b01101010, 9'd1,   4'b1001, 4'd6},  // R6 resume into charging
    '{8'b01101010, 9'd100, 4'b1111, 4'd3},  // R3 powered again
    '{8'b01101011, 9'd2,   4'b1111, 4'd7},  // R7 still synchronising
    '{8'b01101011, 9'd1,   4'b0011, 4'd7},  // R7 switch off, pin released
    '{8'b01101010, 9'd2,   4'b0011, 4'd8},  // R8 release still synchronising
    '{8'b01101010, 9'd1,   4'b1001, 4'd8},  // R8 back to charging
    '{8'b01101010, 9'd100, 4'b1111, 4'd8},  // R8 charges normally afterwards
    '{8'b00101010, 9'd100, 4'b1111, 4'd9},  // R9 off-filter just expired
    '{8'b00101010, 9'd1,   4'b0001, 4'd9}   // R9 idle
  };

  task automatic applyIns(input logic [7:0] v);
    {portAboveOn, portAboveOff, vdsLow, vdsHigh, vgsHigh, tempHot, tempCool, auxReq} = v;
  endtask

  task automatic stepCheck(input int cyc, input logic [3:0] exp, input int req);
    logic [3:0] act;
    repeat (cyc) @(posedge clk);
    @(negedge clk);
    act = {switchEn, limitOper, pgoodRelease, classEn};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d actual=%b expected=%b (sw,oper,pg,cls) at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    applyIns(8'b00000010);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    stepCheck(0, 4'b0001, 12);  // R12 reset state

    for (int i = 0; i < NV; i++) begin
      applyIns(VECS[i].ins);
      stepCheck(int'(VECS[i].cyc), VECS[i].exp, int'(VECS[i].req));
    end

    // R10: no tick, no filter progress
    usTick = 1'b0;
    applyIns(8'b11101010);
    stepCheck(300, 4'b0001, 10);
    usTick = 1'b1;
    stepCheck(100, 4'b0001, 10);
    stepCheck(1, 4'b1001, 10);

    // R11: override during charging and idle keeps switch off
    applyIns(8'b11101011);
    stepCheck(2, 4'b1001, 11);
    stepCheck(1, 4'b0001, 11);
    stepCheck(50, 4'b0001, 11);
    applyIns(8'b11101010);
    stepCheck(3, 4'b1001, 11);

    // R9: lockout wins over thermal shutdown
    applyIns(8'b11101100);
    stepCheck(1, 4'b0000, 6);
    applyIns(8'b00101100);
    stepCheck(100, 4'b0000, 9);
    stepCheck(1, 4'b0001, 9);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule